// File: doc/BRIEF.md
# Multichannel Correlated-Sampling Hit Detector

This block watches four ADC sample streams. Each stream interleaves eight detector channels, so the block serves 32 channels, and each channel receives a new sample every eighth strobe. A single filter datapath in each stream is shared across that stream's eight channels. The filter keeps a short history of samples for every channel. Each time a channel receives a sample, the filter forms a weighted sum of differences between pairs of samples. The pairs sit symmetrically around the centre of the history window. This sum is the pulse height, and it peaks when a rising edge passes through the centre of the window.

There is no trigger input and no gating input. Every channel is filtered all the time. A hit is declared when the pulse height of a channel is above a programmable threshold on two successive samples of that channel. Each hit produces one record with the channel number, the pulse height and a 32-bit timestamp. The timestamp counts sample strobes, one strobe per mux step. The records from all four streams pass through a small merging queue with a valid/ready output. A sticky flag reports when a record had to be dropped.

Software writes the weights, the threshold and the number of active sample pairs through a small write-only register port.

Top module: `corr_hit_detector`

## Requirements
- R1: The channel number of a record is stream index × 8 plus the mux slot. The mux slot is a 3-bit counter that advances on each `smp_valid`. A `smp_valid` that arrives with `frame_start` high is taken as slot 0.
- R2: The pulse height is a sum over the active pairs. Let N be the number of active pairs and let x[j] be the sample taken j samples earlier on the same channel, where x[0] is the current sample. Pair k, for k = 0..N-1, contributes c_k × (x[N-1-k] − x[N+k]). Samples are unsigned 12-bit values. Weights are signed 12-bit values.
- R3: A hit is emitted on the second consecutive sample of a channel whose pulse height is strictly greater than the signed threshold. A single sample above the threshold produces no record.
- R4: After a hit, that channel emits no further hit until one of its samples has a height at or below the threshold.
- R5: A 32-bit timestamp starts at 0 at reset and counts `smp_valid` strobes. Idle cycles do not advance it. A record carries the timestamp value of the sample that completed the hit.
- R6: Register writes use `cfg_we` and `cfg_addr`, with the value on `cfg_wdata`:
  - Addresses 0 to 3 write weight c_k from bits [11:0].
  - Address 4 writes the signed threshold from all 28 bits.
  - Address 5 writes the active pair count minus one from bits [1:0].
  - After reset all weights are 0, the threshold is 0 and four pairs are active.
- R7: A pending record holds `hit_valid` and all of its fields stable until it is accepted. Records leave in sample order. Records from the same sample leave in ascending stream order.
- R8: The queue holds 8 records. A record that arrives while the queue is full is dropped, and `overflow` is set. `overflow` stays set until reset.
- R9: Reset empties the queue, clears `overflow`, and zeroes every channel history and every hit state.
- R10: Channels are independent. Activity on one channel never changes the height or the hit state of another channel, including a channel that shares the same slot in another stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Marks the sample that belongs to mux slot 0 |
| smp_valid | input | 1 | One strobe per mux step; one sample per stream is present |
| smp_data | input | 48 | Four 12-bit unsigned samples; stream s is in bits [12s+11:12s] |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 28 | Register write value |
| hit_valid | output | 1 | A hit record is pending |
| hit_ready | input | 1 | The consumer accepts the pending record |
| hit_chan | output | 5 | Channel number of the record |
| hit_height | output | 28 | Signed pulse height |
| hit_time | output | 32 | Timestamp of the record |
| overflow | output | 1 | Sticky flag: a record was dropped |

## Verification
Noise rejection is checked in two ways. A pulse that crosses the threshold on only one sample must produce no record. A design that fires on the first crossing would add a record that is not expected. Blocking is checked with a slow ramp that stays above the threshold for several samples. A design that does not block would emit a record on every sample of the ramp.

Negative weights, a change of the pair count in mid-run, and the default pair count after reset each move the centre of the window. A design that gets any of these wrong reports the wrong height. For a mid-frame `frame_start`, a design that ignores it reports the wrong channel numbers. For two channels that hit on the same sample, a design with the wrong merge order reports them swapped.

The full-queue test holds the consumer off. It checks that exactly the first eight records survive, in the correct order, and that `overflow` stays set until reset.

// File: rtl/chd_pkg.sv
package chd_pkg;
  localparam int SMP_W    = 12;
  localparam int COEF_W   = 12;
  localparam int PAIR_MAX = 4;
  localparam int WIN_N    = 2 * PAIR_MAX;
  localparam int WIN_IW   = $clog2(WIN_N);
  localparam int PW       = $clog2(PAIR_MAX);
  localparam int HT_W     = SMP_W + COEF_W + PW + 2;
  localparam int TS_W     = 32;
  localparam int CFG_AW   = $clog2(PAIR_MAX + 2);

  typedef logic [WIN_N-1:0][SMP_W-1:0]     win_t;
  typedef logic [PAIR_MAX-1:0][COEF_W-1:0] coefs_t;
  typedef logic signed [HT_W-1:0]          ht_t;
  typedef enum logic [1:0] {RUN_IDLE, RUN_ONE, RUN_HELD} run_e;

  // Weighted sum of symmetric pair differences; w[0] is the newest sample.
  function automatic ht_t pair_height(win_t w, coefs_t c, logic [PW-1:0] pm1);
    ht_t acc, newer, older, wk;
    logic [WIN_IW-1:0] in_idx, out_idx;
    acc = '0;
    for (int k = 0; k < PAIR_MAX; k++) begin
      if (k <= int'(pm1)) begin
        in_idx  = WIN_IW'(int'(pm1) - k);
        out_idx = WIN_IW'(int'(pm1) + 1 + k);
        newer   = ht_t'({1'b0, w[in_idx]});
        older   = ht_t'({1'b0, w[out_idx]});
        wk      = ht_t'($signed(c[k]));
        acc     = acc + wk * (newer - older);
      end
    end
    return acc;
  endfunction
endpackage

// File: rtl/chd_stream_filter.sv
module chd_stream_filter
  import chd_pkg::*;
#(
  parameter int NSLOT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic [$clog2(NSLOT)-1:0] slot,
  input  logic [SMP_W-1:0]         sample,
  input  coefs_t                   coefs,
  input  logic [PW-1:0]            pm1,
  input  ht_t                      thresh,
  output logic                     hit,
  output ht_t                      height
);
  localparam int HIST_N = WIN_N - 1;

  logic [HIST_N-1:0][SMP_W-1:0] hist_q [NSLOT];
  run_e run_q [NSLOT];
  win_t win;
  logic above;
  run_e run_nxt;

  always_comb begin
    win[0] = sample;
    for (int j = 1; j < WIN_N; j++) win[j] = hist_q[slot][j-1];
  end

  assign height = pair_height(win, coefs, pm1);
  assign above  = height > thresh;
  assign hit    = smp_valid && above && (run_q[slot] == RUN_ONE);

  always_comb begin
    if (!above)                    run_nxt = RUN_IDLE;
    else if (run_q[slot] == RUN_IDLE) run_nxt = RUN_ONE;
    else                           run_nxt = RUN_HELD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) begin
        hist_q[s] <= '0;
        run_q[s]  <= RUN_IDLE;
      end
    end else if (smp_valid) begin
      hist_q[slot] <= win[HIST_N-1:0];
      run_q[slot]  <= run_nxt;
    end
  end
endmodule

// File: rtl/chd_hit_fifo.sv
module chd_hit_fifo #(
  parameter int NW    = 4,
  parameter int DEPTH = 8,
  parameter int RW    = 65
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NW-1:0]          we,
  input  logic [NW-1:0][RW-1:0]  wdata,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [RW-1:0]          rd_data,
  output logic                   overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [RW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count, n_acc;
  logic [AW-1:0] place [NW];
  logic [NW-1:0] accept;
  logic pop, drop;

  always_comb begin
    n_acc = '0;
    drop  = 1'b0;
    for (int i = 0; i < NW; i++) begin
      place[i]  = wr_ptr + AW'(n_acc);
      accept[i] = we[i] && ((count + n_acc) < CW'(DEPTH));
      if (we[i] && !accept[i]) drop = 1'b1;
      if (accept[i]) n_acc = n_acc + CW'(1);
    end
  end

  assign rd_valid = count != '0;
  assign rd_data  = mem[rd_ptr];
  assign pop      = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NW; i++)
      if (accept[i]) mem[place[i]] <= wdata[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr + AW'(n_acc);
      rd_ptr <= rd_ptr + AW'(pop);
      count  <= count + n_acc - CW'(pop);
      if (drop) overflow <= 1'b1;
    end
  end

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R7
  hold_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
endmodule

// File: rtl/corr_hit_detector.sv
module corr_hit_detector
  import chd_pkg::*;
#(
  parameter int NSTREAM    = 4,
  parameter int NSLOT      = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               frame_start,
  input  logic                               smp_valid,
  input  logic [NSTREAM*SMP_W-1:0]           smp_data,
  input  logic                               cfg_we,
  input  logic [CFG_AW-1:0]                  cfg_addr,
  input  logic [HT_W-1:0]                    cfg_wdata,
  output logic                               hit_valid,
  input  logic                               hit_ready,
  output logic [$clog2(NSTREAM*NSLOT)-1:0]   hit_chan,
  output logic [HT_W-1:0]                    hit_height,
  output logic [TS_W-1:0]                    hit_time,
  output logic                               overflow
);
  localparam int SLW   = $clog2(NSLOT);
  localparam int CHW   = $clog2(NSTREAM * NSLOT);
  localparam int REC_W = CHW + HT_W + TS_W;
  localparam logic [CFG_AW-1:0] ADDR_THR   = CFG_AW'(PAIR_MAX);
  localparam logic [CFG_AW-1:0] ADDR_PAIRS = CFG_AW'(PAIR_MAX + 1);

  coefs_t         coefs_q;
  ht_t            thresh_q;
  logic [PW-1:0]  pm1_q;
  logic [SLW-1:0] slot_q, slot_now;
  logic [TS_W-1:0] ts_q;

  logic [NSTREAM-1:0]            hit_event;
  ht_t                           height_s [NSTREAM];
  logic [NSTREAM-1:0][REC_W-1:0] rec;
  logic [REC_W-1:0]              head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coefs_q  <= '0;
      thresh_q <= '0;
      pm1_q    <= PW'(PAIR_MAX - 1);
    end else if (cfg_we) begin
      if (cfg_addr < ADDR_THR) coefs_q[cfg_addr[PW-1:0]] <= cfg_wdata[COEF_W-1:0];
      else if (cfg_addr == ADDR_THR) thresh_q <= cfg_wdata;
      else if (cfg_addr == ADDR_PAIRS) pm1_q <= cfg_wdata[PW-1:0];
    end
  end

  assign slot_now = frame_start ? '0 : slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      ts_q   <= '0;
    end else if (smp_valid) begin
      slot_q <= (slot_now == SLW'(NSLOT - 1)) ? '0 : slot_now + SLW'(1);
      ts_q   <= ts_q + TS_W'(1);
    end
  end

  for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
    chd_stream_filter #(.NSLOT(NSLOT)) u_flt (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .slot      (slot_now),
      .sample    (smp_data[s*SMP_W +: SMP_W]),
      .coefs     (coefs_q),
      .pm1       (pm1_q),
      .thresh    (thresh_q),
      .hit       (hit_event[s]),
      .height    (height_s[s])
    );
    assign rec[s] = {CHW'(s * NSLOT) + CHW'(slot_now), height_s[s], ts_q};
  end

  chd_hit_fifo #(.NW(NSTREAM), .DEPTH(FIFO_DEPTH), .RW(REC_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (hit_event),
    .wdata    (rec),
    .rd_valid (hit_valid),
    .rd_ready (hit_ready),
    .rd_data  (head),
    .overflow (overflow)
  );

  assign {hit_chan, hit_height, hit_time} = head;

  // R1
  resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && frame_start |=> slot_q == SLW'(1));
  // R5
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> ts_q == $past(ts_q) + TS_W'(1));
  // R5
  ts_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(ts_q));
endmodule

// File: tb/corr_hit_detector_test.sv
module corr_hit_detector_test;
  typedef struct packed {
    logic [1:0]         op;   // 0: set level and run n frames, 1: register write
    logic [7:0]         a;
    logic signed [31:0] b;
    logic [7:0]         n;
  } step_t;

  localparam int NSTEP = 34;
  localparam step_t STEPS [NSTEP] = '{
    '{2'd1, 8'd5, 32'sd1, 8'd0},     '{2'd1, 8'd0, 32'sd2, 8'd0},
    '{2'd1, 8'd1, 32'sd1, 8'd0},     '{2'd1, 8'd4, 32'sd100, 8'd0},
    '{2'd0, 8'd5, 32'sd500, 8'd4},   '{2'd0, 8'd5, 32'sd0, 8'd4},
    '{2'd0, 8'd20, 32'sd60, 8'd1},   '{2'd0, 8'd20, 32'sd0, 8'd4},
    '{2'd0, 8'd31, 32'sd300, 8'd3},  '{2'd0, 8'd31, 32'sd0, 8'd4},
    '{2'd0, 8'd2, 32'sd2000, 8'd0},  '{2'd0, 8'd10, 32'sd2000, 8'd6},
    '{2'd0, 8'd2, 32'sd0, 8'd0},     '{2'd0, 8'd10, 32'sd0, 8'd6},
    '{2'd1, 8'd5, 32'sd0, 8'd0},     '{2'd1, 8'd0, 32'sd1, 8'd0},
    '{2'd1, 8'd4, 32'sd150, 8'd0},   '{2'd0, 8'd7, 32'sd200, 8'd1},
    '{2'd0, 8'd7, 32'sd400, 8'd1},   '{2'd0, 8'd7, 32'sd600, 8'd1},
    '{2'd0, 8'd7, 32'sd800, 8'd4},   '{2'd0, 8'd7, 32'sd1000, 8'd1},
    '{2'd0, 8'd7, 32'sd1200, 8'd3},  '{2'd1, 8'd0, -32'sd3, 8'd0},
    '{2'd0, 8'd7, 32'sd1000, 8'd1},  '{2'd0, 8'd7, 32'sd800, 8'd3},
    '{2'd1, 8'd5, 32'sd3, 8'd0},     '{2'd1, 8'd1, 32'sd1, 8'd0},
    '{2'd1, 8'd2, 32'sd1, 8'd0},     '{2'd1, 8'd3, 32'sd1, 8'd0},
    '{2'd1, 8'd0, 32'sd1, 8'd0},     '{2'd1, 8'd4, 32'sd1000, 8'd0},
    '{2'd0, 8'd12, 32'sd400, 8'd8},  '{2'd0, 8'd12, 32'sd0, 8'd8}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 1'b0, smp_valid = 1'b0, cfg_we = 1'b0, hit_ready = 1'b1;
  logic [47:0] smp_data = '0;
  logic [2:0]  cfg_addr = '0;
  logic [27:0] cfg_wdata = '0;
  logic hit_valid, overflow;
  logic [4:0]  hit_chan;
  logic [27:0] hit_height;
  logic [31:0] hit_time;

  always #2 clk = ~clk;

  corr_hit_detector uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .smp_valid(smp_valid),
    .smp_data(smp_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_chan(hit_chan),
    .hit_height(hit_height), .hit_time(hit_time), .overflow(overflow)
  );

  int vectors = 0, fails = 0;
  int level [32];
  int hist_m [32][8];
  int run_m [32];
  int c_m [4];
  int np_m, thr_m, ts_m, bslot;
  bit model_on;
  int q_ch [256], q_ht [256], q_ts [256];
  int qh, qt;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin
      level[i] = 0; run_m[i] = 0;
      for (int j = 0; j < 8; j++) hist_m[i][j] = 0;
    end
    for (int k = 0; k < 4; k++) c_m[k] = 0;
    np_m = 4; thr_m = 0; ts_m = 0; bslot = 0; qh = 0; qt = 0;
  endtask

  // Height from R2 as the weighted newer-half sum minus the weighted older-half sum.
  task automatic model_sample(input int ch, input int val);
    int y, up, dn;
    for (int j = 7; j > 0; j--) hist_m[ch][j] = hist_m[ch][j-1];
    hist_m[ch][0] = val;
    up = 0; dn = 0;
    for (int k = 0; k < np_m; k++) begin
      up += c_m[k] * hist_m[ch][np_m-1-k];
      dn += c_m[k] * hist_m[ch][np_m+k];
    end
    y = up - dn;
    if (y > thr_m) begin
      if (run_m[ch] == 1) begin
        q_ch[qt] = ch; q_ht[qt] = y; q_ts[qt] = ts_m; qt++;
      end
      run_m[ch] = (run_m[ch] == 0) ? 1 : 2;
    end else run_m[ch] = 0;
  endtask

  task automatic check_out();
    if (hit_valid) begin
      if (qh == qt) chk(1'b0, "R3 R4 unexpected record chan", int'(hit_chan), -1);
      else begin
        chk(int'(hit_chan) == q_ch[qh], "R1 R7 R10 chan", int'(hit_chan), q_ch[qh]);
        chk(int'($signed(hit_height)) == q_ht[qh], "R2 height", int'($signed(hit_height)), q_ht[qh]);
        chk(int'(hit_time) == q_ts[qh], "R5 time", int'(hit_time), q_ts[qh]);
        qh++;
      end
    end
  endtask

  task automatic tick(input bit v);
    @(negedge clk);
    if (model_on) check_out();
    cfg_we = 1'b0;
    smp_valid = v;
    frame_start = v && (bslot == 0);
    if (v) begin
      for (int s = 0; s < 4; s++) begin
        smp_data[s*12 +: 12] = 12'(level[s*8 + bslot]);
        model_sample(s*8 + bslot, level[s*8 + bslot]);
      end
      ts_m++;
      bslot = (bslot + 1) % 8;
    end
  endtask

  task automatic cfg_write(input int addr, input int val);
    @(negedge clk);
    if (model_on) check_out();
    smp_valid = 1'b0; frame_start = 1'b0;
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 28'(val);
    if (addr < 4) c_m[addr] = val;
    else if (addr == 4) thr_m = val;
    else np_m = (val & 3) + 1;
  endtask

  task automatic run_frame();
    repeat (8) tick(1'b1);
    tick(1'b0);
  endtask

  task automatic drain_check(input string tag);
    repeat (16) tick(1'b0);
    chk(qh == qt && !hit_valid, tag, qt - qh, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0; frame_start = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic run_all();
    model_on = 1'b1;
    do_reset();
    tick(1'b0);
    // R9: reset state
    chk(!hit_valid, "R9 hit_valid after reset", int'(hit_valid), 0);
    chk(!overflow, "R9 overflow after reset", int'(overflow), 0);

    for (int i = 0; i < NSTEP; i++) begin
      if (STEPS[i].op == 2'd1) cfg_write(int'(STEPS[i].a), int'(STEPS[i].b));
      else begin
        level[STEPS[i].a] = int'(STEPS[i].b);
        for (int f = 0; f < int'(STEPS[i].n); f++) run_frame();
      end
    end
    drain_check("R3 R4 pending records after table");
    chk(!overflow, "R8 no drop in table", int'(overflow), 0);

    // R1: frame_start in mid-frame realigns the slot counter
    repeat (3) tick(1'b1);
    bslot = 0;
    level[13] = 600;
    repeat (6) run_frame();
    level[13] = 0;
    repeat (6) run_frame();
    drain_check("R1 records after resync");

    // R8 R7: full queue with consumer stalled
    do_reset();
    model_on = 1'b0;
    cfg_write(5, 0); cfg_write(0, 1); cfg_write(4, 0);
    hit_ready = 1'b0;
    for (int i = 0; i < 32; i++) level[i] = 50;
    run_frame();
    for (int i = 0; i < 32; i++) level[i] = 100;
    run_frame();
    tick(1'b0);
    chk(overflow === 1'b1, "R8 overflow set", int'(overflow), 1);
    chk(hit_valid && hit_chan == 5'd0, "R7 head chan", int'(hit_chan), 0);
    chk(hit_time == 32'd8, "R5 head time", int'(hit_time), 8);
    chk(int'($signed(hit_height)) == 50, "R2 head height", int'($signed(hit_height)), 50);
    repeat (3) tick(1'b0);
    chk(hit_valid && hit_chan == 5'd0 && hit_time == 32'd8, "R7 head held", int'(hit_chan), 0);
    hit_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      chk(hit_valid && int'(hit_chan) == (i % 4) * 8 + i / 4, "R7 merge order",
          int'(hit_chan), (i % 4) * 8 + i / 4);
      tick(1'b0);
    end
    chk(!hit_valid, "R8 dropped records absent", int'(hit_valid), 0);
    chk(overflow === 1'b1, "R8 overflow sticky", int'(overflow), 1);

    // R9 then R6: default pair count after reset
    do_reset();
    tick(1'b0);
    chk(!overflow && !hit_valid, "R9 overflow cleared by reset", int'(overflow), 0);
    model_on = 1'b1;
    cfg_write(0, 1); cfg_write(1, 1); cfg_write(2, 1); cfg_write(3, 1); cfg_write(4, 1000);
    level[12] = 400;
    repeat (8) run_frame();
    level[12] = 0;
    repeat (8) run_frame();
    drain_check("R6 default pairs records");
    chk(vectors > 30, "R6 record checks made", vectors, 31);
  endtask

  initial begin
    model_reset();
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule